// File: doc/BRIEF.md
# Keyed-Sequence Software Watchdog

This block guards against runaway software. A free-running timeout counter, clocked from the system clock directly or through a divide-by-2^PRE_LOG2 prescaler, must be restarted periodically by software. Software restarts it by writing two key bytes to a service port: first 0x55, then 0xAA. Any amount of time may pass between the two writes. If the pair is not completed before the counter reaches its limit, the block emits a one-cycle reset request. The counter then starts again from zero.

A 4-bit control word selects the enable, the prescaler and one of four timeout lengths. This word accepts exactly one write after reset. After that it is frozen, but it can always be read back. A changed prescale or timing choice reaches the counter only when the next key pair completes. A debug freeze input, gated by a hold-enable input, can stall the counter.

Two state machines drive the behaviour. The key sequencer has two states. KS_IDLE waits for 0x55 and moves to KS_ARMED on that value. From KS_ARMED, the block moves back to KS_IDLE in three cases: a 0xAA completes the service, any other value is written (0x55 is the exception and keeps KS_ARMED), or a timeout occurs. The control-word guard has two states. CFG_OPEN moves to CFG_LOCKED on the first control write. CFG_LOCKED has no exit except reset.

Top module: `keyed_watchdog`

## Requirements
- R1: Reset values:
  - `rst_req` is low.
  - `svc_rdata` is 0.
  - `cfg_rdata` shows enable=1, timing=00 and prescale equal to `strap_pre`.
  - The key sequencer is in KS_IDLE.
- R2: With the prescaler off, timing codes 00, 01, 10 and 11 give timeouts of 2^BASE_LOG2, 2^(BASE_LOG2+2), 2^(BASE_LOG2+4) and 2^(BASE_LOG2+6) counted clocks. With the defaults these are 2^9, 2^11, 2^13 and 2^15.
- R3: With the prescaler on, every timeout is multiplied by 2^PRE_LOG2. With the defaults the timeouts are 2^18, 2^20, 2^22 and 2^24.
- R4: A service write of 0x55 followed by a service write of 0xAA, with any gap between them, restarts the count at zero.
- R5: Writes that do not complete a service do not restart the count:
  - In KS_ARMED, a value other than 0x55 or 0xAA returns the sequencer to KS_IDLE.
  - A 0xAA written in KS_IDLE has no effect.
- R6: When the count reaches the active timeout, `rst_req` is high for exactly one cycle. The count restarts from zero and the sequencer returns to KS_IDLE.
- R7: The control word has the layout bit0 = enable, bit1 = prescale, bits[3:2] = timing. Only the first write after reset is accepted. `cfg_rdata` shows the stored word at all times.
- R8: The prescale and timing values stored in the control word take effect only when a key pair completes.
- R9: With `freeze` and `freeze_hold_en` both high, the counter does not advance. With `freeze_hold_en` low, `freeze` has no effect.
- R10: The prescale reset value is the `strap_pre` level while reset is asserted.
- R11: With enable = 0, the count is held at zero and no `rst_req` is produced.
- R12: `svc_rdata` always reads zero.
- R13: A key pair that completes in the same cycle in which the timeout would fire suppresses the request and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pre | input | 1 | Mode strap sampled during reset for the prescale bit |
| freeze | input | 1 | Debug freeze indication |
| freeze_hold_en | input | 1 | Lets `freeze` stall the counter |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word write data |
| cfg_rdata | output | 4 | Control word read data |
| svc_wr | input | 1 | Service key write strobe |
| svc_wdata | input | 8 | Service key value |
| svc_rdata | output | 8 | Service port read data (always zero) |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions rely on several assumptions about the inputs:
- `rst_n` is released synchronously to the clock.
- BASE_LOG2 is at least 1, so two expiries can never fall in adjacent cycles.
- Write strobes are only sampled at clock edges, so key values are stable around each edge.

The stimulus follows these rules:
- Every input changes on the falling edge.
- Resets last several cycles and are released on a falling edge.
- The bench uses small BASE_LOG2 and PRE_LOG2 values, so every timing code with and without the prescaler fits within a short run.

A behavioural model counts clocks against the timeout limit and is compared with `rst_req`, `cfg_rdata` and `svc_rdata` on every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    // bit0 enable, bit1 prescale, bits[3:2] timing
    typedef struct packed {
        logic [1:0] tsel;
        logic       pre;
        logic       en;
    } wdg_cfg_t;

    typedef enum logic {
        KS_IDLE,
        KS_ARMED
    } key_state_e;

    typedef enum logic {
        CFG_OPEN,
        CFG_LOCKED
    } cfg_state_e;

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap_pre,
    input  logic     wr,
    input  wdg_cfg_t wdata,
    output wdg_cfg_t cfg
);

    cfg_state_e state_q, state_d;
    wdg_cfg_t   cfg_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (wr) state_d = CFG_LOCKED;
            CFG_LOCKED: state_d = CFG_LOCKED;
            default:    state_d = CFG_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CFG_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en   <= 1'b1;
            cfg_q.pre  <= strap_pre;
            cfg_q.tsel <= 2'b00;
        end else if (state_q == CFG_OPEN && wr) begin
            cfg_q <= wdata;
        end
    end

    assign cfg = cfg_q;

    AST_CFG_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == CFG_LOCKED |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       expire,
    output logic       done
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (expire) begin
            state_d = KS_IDLE;
        end else if (wr) begin
            unique case (state_q)
                KS_IDLE:  state_d = (wdata == KEY_FIRST) ? KS_ARMED : KS_IDLE;
                KS_ARMED: state_d = (wdata == KEY_FIRST) ? KS_ARMED : KS_IDLE;
                default:  state_d = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done = 1'b0;
        unique case (state_q)
            KS_IDLE:  done = 1'b0;
            KS_ARMED: done = wr && (wdata == KEY_SECOND);
            default:  done = 1'b0;
        endcase
    end

    AST_KEY_BAD_VALUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_ARMED && wr && wdata != KEY_FIRST && wdata != KEY_SECOND)
        |=> state_q == KS_IDLE); // R5

    AST_KEY_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> state_q == KS_IDLE); // R6

endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout #(
    parameter int BASE_LOG2 = 9,
    parameter int PRE_LOG2  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_pre,
    input  logic       en,
    input  logic       hold,
    input  logic       cfg_pre,
    input  logic [1:0] cfg_tsel,
    input  logic       reload,
    output logic       expire,
    output logic       rst_req
);

    localparam int CNT_W = BASE_LOG2 + 6;

    logic [PRE_LOG2-1:0] pcnt_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    last_val;
    logic [2:0]          shamt;
    logic                act_pre_q;
    logic [1:0]          act_tsel_q;
    logic                tick;
    logic                run;
    logic                req_q;

    assign run   = en && !hold;
    assign tick  = !act_pre_q || (&pcnt_q);
    assign shamt = 3'd6 - {act_tsel_q, 1'b0};

    always_comb begin
        last_val = {CNT_W{1'b1}} >> shamt;
    end

    assign expire = run && !reload && tick && (cnt_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q     <= '0;
            cnt_q      <= '0;
            act_pre_q  <= strap_pre;
            act_tsel_q <= 2'b00;
            req_q      <= 1'b0;
        end else if (reload) begin
            pcnt_q     <= '0;
            cnt_q      <= '0;
            act_pre_q  <= cfg_pre;
            act_tsel_q <= cfg_tsel;
            req_q      <= 1'b0;
        end else if (!en) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
            req_q  <= 1'b0;
        end else if (hold) begin
            req_q <= 1'b0;
        end else begin
            if (act_pre_q) pcnt_q <= pcnt_q + 1'b1;
            if (tick) begin
                cnt_q <= expire ? '0 : cnt_q + 1'b1;
            end
            req_q <= expire;
        end
    end

    assign rst_req = req_q;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q); // R6

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req_q); // R11

    AST_FREEZE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hold && !reload) |=> $stable(cnt_q)); // R9

    AST_TIMING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ($stable(act_tsel_q) && $stable(act_pre_q))); // R8

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 9,
    parameter int PRE_LOG2  = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_pre,
    input  logic       freeze,
    input  logic       freeze_hold_en,
    input  logic       cfg_wr,
    input  logic [3:0] cfg_wdata,
    output logic [3:0] cfg_rdata,
    input  logic       svc_wr,
    input  logic [7:0] svc_wdata,
    output logic [7:0] svc_rdata,
    output logic       rst_req
);

    wdg_cfg_t cfg;
    logic     svc_done;
    logic     expire;

    wdg_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_pre (strap_pre),
        .wr        (cfg_wr),
        .wdata     (wdg_cfg_t'(cfg_wdata)),
        .cfg       (cfg)
    );

    wdg_key_fsm u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (svc_wr),
        .wdata  (svc_wdata),
        .expire (expire),
        .done   (svc_done)
    );

    wdg_timeout #(
        .BASE_LOG2 (BASE_LOG2),
        .PRE_LOG2  (PRE_LOG2)
    ) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_pre (strap_pre),
        .en        (cfg.en),
        .hold      (freeze && freeze_hold_en),
        .cfg_pre   (cfg.pre),
        .cfg_tsel  (cfg.tsel),
        .reload    (svc_done),
        .expire    (expire),
        .rst_req   (rst_req)
    );

    assign cfg_rdata = cfg;
    assign svc_rdata = '0;

    AST_SERVICE_SUPPRESSES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> !rst_req); // R13

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 4;
    localparam int PRE  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_pre = 1'b0;
    logic       freeze = 1'b0;
    logic       freeze_hold_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic [3:0] cfg_rdata;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_wdata = '0;
    logic [7:0] svc_rdata;
    logic       rst_req;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    finished = 0;
    string tag = "R1";

    // behavioural reference state
    bit   m_en, m_pre, m_lock, m_apre, m_armed, m_req;
    bit [1:0] m_tim, m_atim;
    int   m_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog #(.BASE_LOG2(BASE), .PRE_LOG2(PRE)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_pre      (strap_pre),
        .freeze         (freeze),
        .freeze_hold_en (freeze_hold_en),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .cfg_rdata      (cfg_rdata),
        .svc_wr         (svc_wr),
        .svc_wdata      (svc_wdata),
        .svc_rdata      (svc_rdata),
        .rst_req        (rst_req)
    );

    function automatic int limit_of(bit pre, bit [1:0] t);
        return 1 << (BASE + 2 * int'(t) + (pre ? PRE : 0));
    endfunction

    task automatic model_step();
        bit done, exp_now;
        if (!rst_n) begin
            m_en = 1; m_pre = strap_pre; m_tim = 0; m_lock = 0;
            m_apre = strap_pre; m_atim = 0; m_armed = 0; m_req = 0; m_count = 0;
            return;
        end
        done = m_armed && svc_wr && svc_wdata == 8'hAA;
        exp_now = 0;
        if (done) begin
            m_count = 0; m_apre = m_pre; m_atim = m_tim; m_req = 0;
        end else if (!m_en) begin
            m_count = 0; m_req = 0;
        end else if (freeze && freeze_hold_en) begin
            m_req = 0;
        end else begin
            m_count++;
            if (m_count == limit_of(m_apre, m_atim)) begin
                exp_now = 1; m_count = 0; m_req = 1;
            end else begin
                m_req = 0;
            end
        end
        if (exp_now) m_armed = 0;
        else if (svc_wr) m_armed = (svc_wdata == 8'h55);
        if (cfg_wr && !m_lock) begin
            m_en = cfg_wdata[0]; m_pre = cfg_wdata[1]; m_tim = cfg_wdata[3:2]; m_lock = 1;
        end
    endtask

    task automatic compare();
        n_vec++;
        if (rst_req !== m_req) begin
            n_bad++;
            $display("FAIL %s: rst_req got %0b exp %0b at %0t", tag, rst_req, m_req, $time);
        end
        n_vec++;
        if (cfg_rdata !== {m_tim, m_pre, m_en}) begin
            n_bad++;
            $display("FAIL R7: cfg_rdata got %h exp %h", cfg_rdata, {m_tim, m_pre, m_en});
        end
        n_vec++;
        if (svc_rdata !== 8'h00) begin
            n_bad++;
            $display("FAIL R12: svc_rdata got %h exp 00", svc_rdata);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        repeat (n) cycle();
    endtask

    task automatic key(logic [7:0] v);
        svc_wr = 1; svc_wdata = v;
        cycle();
        svc_wr = 0; svc_wdata = 0;
    endtask

    task automatic cfg_write(logic [3:0] v);
        cfg_wr = 1; cfg_wdata = v;
        cycle();
        cfg_wr = 0; cfg_wdata = 0;
    endtask

    task automatic do_reset(bit s);
        rst_n = 0; strap_pre = s;
        run(3);
        rst_n = 1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        do_reset(0);
        run(3);
        // R6: pulses recur with the default code
        tag = "R6";
        run(40);
        // R4: service pairs with gaps
        tag = "R4";
        for (int g = 0; g < 6; g++) begin
            key(8'h55); run(g); key(8'hAA); run(8);
        end
        run(20);
        // R5: wrong keys do not reload
        tag = "R5";
        key(8'hAA); run(3);
        key(8'h55); key(8'h12); key(8'hAA); run(20);
        key(8'h55); key(8'h55); key(8'hAA); run(5);
        key(8'h55); key(8'h00); run(20);
        // R13: completion at varying offsets around expiry
        tag = "R13";
        for (int k = 11; k < 19; k++) begin
            key(8'h55); key(8'hAA);
            run(k - 3);
            key(8'h55); key(8'hAA);
            run(2);
        end
        // R7 / R8: write once, delayed application
        tag = "R8";
        do_reset(0);
        cfg_write(4'b1001);
        cfg_write(4'b0110);
        run(40);
        key(8'h55); key(8'hAA);
        run(300);
        // R2 / R3: all codes with and without prescaler
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 4; t++) begin
                tag = p ? "R3" : "R2";
                do_reset(0);
                cfg_write({t[1:0], p[0], 1'b1});
                key(8'h55); key(8'hAA);
                run(2 * limit_of(p[0], t[1:0]) + 5);
            end
        end
        // R9: freeze behaviour
        tag = "R9";
        do_reset(0);
        run(5);
        freeze_hold_en = 1; freeze = 1; run(50);
        freeze = 0; run(30);
        freeze_hold_en = 0; freeze = 1; run(40);
        freeze = 0;
        // R11: disabled
        tag = "R11";
        do_reset(0);
        cfg_write(4'b1100);
        run(100);
        key(8'h55); key(8'hAA); run(50);
        // R10: strap-selected prescale
        tag = "R10";
        do_reset(1);
        run(300);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R6: watchdog expired got running exp finished");
            summary();
            $finish;
        end
    end

endmodule